// File: doc/BRIEF.md
# Multicore reset and boot controller

This block is a word-addressed register file that sits on a simple 32-bit register bus and turns software writes into per-core control events for a four-core cluster. Writing its control register produces single-cycle reset strobes for any core, and power-on or power-off strobes for the three secondary cores. Each power-on strobe comes with an entry address and an argument taken from that core's own pair of general registers.

Request bits in the control register act on the difference between the written word and the stored word, and then clear themselves. When a core's enable bit changes, that change consumes the same core's reset request, so that core gets a power strobe but no reset strobe. Two further reset bits, one for each display unit, are taken in and cleared with no other effect.

The other registers are plain storage: a reset-status register, an interrupt-mask register, a status register, two boot-mode registers and ten general registers. An access outside the register file, or an access that is not word-aligned, raises an error flag in the same cycle.

Top module: `core_boot_ctrl`

## Requirements
- R1: After synchronous reset the control register (index 0) reads 0x521, reset status (index 1) reads 0x1, interrupt mask (index 2) reads 0x1F, and indices 3..15 read 0.
- R2: The register index is the byte address shifted right by 2. The map is: 0 control, 1 reset status, 2 interrupt mask, 3 status, 4 and 5 boot mode, and 6..15 general registers 1..10 (general register k at index 5+k). A write to any index other than 0 stores the data unchanged. Read data is combinational from the address.
- R3: An access to an index of 16 or more, or to an address whose low two bits are not 00, reads as 0 and leaves every register unchanged when written. In that cycle `bus_err` is 1 if `bus_we` or `bus_re` is 1. In every other cycle `bus_err` is 0.
- R4: A control write that changes core N's enable bit (bit 21+N, N = 1..3) to 1 gives a one-cycle `core_on_pulse[N]`. In the same cycle the N-th 32-bit slice of `core_entry_addr` holds general register 2N+1 and the N-th slice of `core_entry_arg` holds general register 2N+2. Both slices are 0 when the pulse is 0.
- R5: A control write that changes core N's enable bit to 0 gives a one-cycle `core_off_pulse[N]`.
- R6: When core N's enable bit changes, core N's reset bit (bit 13+N) is stored as 0 and no reset strobe is issued for core N on that write.
- R7: A control write in which core N's reset bit (bit 13+N, N = 0..3) differs from the stored value gives a one-cycle `core_rst_pulse[N]`, and that bit is stored as 0.
- R8: A change in either display-unit reset bit (bits 3 and 12) stores that bit as 0 and produces no strobe.
- R9: All other control bits are stored as written. A control write with no difference from the stored value produces no strobe.
- R10: Strobes appear in the cycle after the accepted control write, on the same edge that updates the control register, and are 0 in every other cycle. Core 0 never receives a power-on or power-off strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address inside the 4 KB window |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (used only for the error flag) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| bus_err | output | 1 | Bad-address flag for the current access |
| core_rst_pulse | output | 4 | Per-core reset strobe |
| core_on_pulse | output | 4 | Per-core power-on strobe (bit 0 always 0) |
| core_off_pulse | output | 4 | Per-core power-off strobe (bit 0 always 0) |
| core_entry_addr | output | 128 | Per-core entry address, 32 bits per core |
| core_entry_arg | output | 128 | Per-core entry argument, 32 bits per core |

## Verification
A stale control word is the main internal fault this block can have. If a request bit is left set, the next write computes its change mask against the wrong value: a later write of 0 then fires a spurious strobe, or a repeated request is missed. Either shows up one cycle after that write, and a read of index 0 exposes it at once. A wrong general-register slice shows up as a wrong address or argument in the same cycle as the power-on strobe. A misdecoded address shows up as a wrong `bus_rdata` or `bus_err` in the access cycle itself.

// File: rtl/cbc_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the multicore reset and boot controller.
// Holds the register index map, the control-register bit positions and the
// per-register reset values. Assumes four cores and a 32-bit register word.
package cbc_pkg;

    localparam int CBC_DW        = 32;
    localparam int CBC_NCORES    = 4;
    localparam int CBC_NREGS     = 16;

    // register indices (word index = byte address >> 2)
    localparam int IDX_CTRL      = 0;
    localparam int IDX_RSTAT     = 1;
    localparam int IDX_IMASK     = 2;
    localparam int IDX_STATUS    = 3;
    localparam int IDX_BOOTA     = 4;
    localparam int IDX_BOOTB     = 5;
    localparam int IDX_GP_BASE   = 5;   // general register k lives at 5+k

    // control-register bit positions
    localparam int BIT_DISP1     = 3;
    localparam int BIT_DISP2     = 12;
    localparam int BIT_RST_BASE  = 13;  // core n reset at 13+n
    localparam int BIT_EN_BASE   = 21;  // core n enable at 21+n (n >= 1)

    localparam logic [31:0] CTRL_RESET_VAL  = 32'h0000_0521;
    localparam logic [31:0] RSTAT_RESET_VAL = 32'h0000_0001;
    localparam logic [31:0] IMASK_RESET_VAL = 32'h0000_001F;

    // Reset value of the register at a given index.
    function automatic logic [31:0] reg_reset_value(input int idx);
        case (idx)
            IDX_CTRL:  return CTRL_RESET_VAL;
            IDX_RSTAT: return RSTAT_RESET_VAL;
            IDX_IMASK: return IMASK_RESET_VAL;
            default:   return 32'h0;
        endcase
    endfunction

    // Index of the general register that holds core n's entry address.
    function automatic int entry_addr_idx(input int n);
        return IDX_GP_BASE + 2 * n + 1;
    endfunction

    // Index of the general register that holds core n's entry argument.
    function automatic int entry_arg_idx(input int n);
        return IDX_GP_BASE + 2 * n + 2;
    endfunction

endpackage

// File: rtl/cbc_regfile.sv
`timescale 1ns/1ps
// Module: cbc_regfile
// Flat bank of NREGS words with per-index reset values from cbc_pkg.
// One write port; the word to store is already final (the control
// register's self-clearing is resolved upstream). All words are exposed
// flat so the caller can read and tap them without extra ports.
module cbc_regfile #(
    parameter int DW    = 32,
    parameter int NREGS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(NREGS)-1:0] wr_idx,
    input  logic [DW-1:0]            wr_data,
    output logic [NREGS*DW-1:0]      regs_flat
);

    localparam int IW = $clog2(NREGS);

    for (genvar g = 0; g < NREGS; g++) begin : g_word
        logic [DW-1:0] word_q;

        // Holds one register word; loads it on a write to its index.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= DW'(cbc_pkg::reg_reset_value(g));
            end else if (wr_en && (wr_idx == IW'(g))) begin
                word_q <= wr_data;
            end
        end

        assign regs_flat[g*DW +: DW] = word_q;
    end

endmodule

// File: rtl/cbc_ctrl_decode.sv
`timescale 1ns/1ps
// Module: cbc_ctrl_decode
// Combinational decode of a control-register write. It forms the change
// mask (stored XOR written), turns enable changes into power requests and
// reset-bit changes into reset requests, and computes the word to store
// with every self-clearing bit forced low. The requests are 0 unless
// apply is high. Assumes the bit layout in cbc_pkg.
module cbc_ctrl_decode
    import cbc_pkg::*;
#(
    parameter int DW     = 32,
    parameter int NCORES = 4
) (
    input  logic              apply,
    input  logic [DW-1:0]     ctrl_q,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     ctrl_store,
    output logic [NCORES-1:0] rst_req,
    output logic [NCORES-1:0] on_req,
    output logic [NCORES-1:0] off_req
);

    logic [DW-1:0] chg;

    // Resolves the written word into stored value and per-core requests.
    always_comb begin
        ctrl_store = wdata;
        chg        = ctrl_q ^ wdata;
        rst_req    = '0;
        on_req     = '0;
        off_req    = '0;
        // enable changes take priority and consume the same core's reset
        for (int n = 1; n < NCORES; n++) begin
            if (chg[BIT_EN_BASE + n]) begin
                if (wdata[BIT_EN_BASE + n]) begin
                    on_req[n] = 1'b1;
                end else begin
                    off_req[n] = 1'b1;
                end
                ctrl_store[BIT_RST_BASE + n] = 1'b0;
                chg[BIT_RST_BASE + n]        = 1'b0;
            end
        end
        // remaining reset-bit changes fire reset requests
        for (int n = 0; n < NCORES; n++) begin
            if (chg[BIT_RST_BASE + n]) begin
                rst_req[n]                   = 1'b1;
                ctrl_store[BIT_RST_BASE + n] = 1'b0;
            end
        end
        // display-unit resets are taken in and cleared with no other action
        if (chg[BIT_DISP1]) ctrl_store[BIT_DISP1] = 1'b0;
        if (chg[BIT_DISP2]) ctrl_store[BIT_DISP2] = 1'b0;
        if (!apply) begin
            rst_req = '0;
            on_req  = '0;
            off_req = '0;
        end
    end

endmodule

// File: rtl/cbc_strobe_reg.sv
`timescale 1ns/1ps
// Module: cbc_strobe_reg
// Registers the per-core requests as single-cycle strobes. Entry address
// and argument slices are loaded only with a power-on request, and are 0
// otherwise. Assumes the requests are already one cycle wide.
module cbc_strobe_reg #(
    parameter int DW     = 32,
    parameter int NCORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCORES-1:0]    rst_req,
    input  logic [NCORES-1:0]    on_req,
    input  logic [NCORES-1:0]    off_req,
    input  logic [NCORES*DW-1:0] entry_in,
    input  logic [NCORES*DW-1:0] arg_in,
    output logic [NCORES-1:0]    rst_pulse,
    output logic [NCORES-1:0]    on_pulse,
    output logic [NCORES-1:0]    off_pulse,
    output logic [NCORES*DW-1:0] entry_out,
    output logic [NCORES*DW-1:0] arg_out
);

    // Captures this cycle's requests; all outputs fall back to 0 next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pulse <= '0;
            on_pulse  <= '0;
            off_pulse <= '0;
            entry_out <= '0;
            arg_out   <= '0;
        end else begin
            rst_pulse <= rst_req;
            on_pulse  <= on_req;
            off_pulse <= off_req;
            for (int n = 0; n < NCORES; n++) begin
                entry_out[n*DW +: DW] <= on_req[n] ? entry_in[n*DW +: DW] : '0;
                arg_out[n*DW +: DW]   <= on_req[n] ? arg_in[n*DW +: DW]   : '0;
            end
        end
    end

endmodule

// File: rtl/core_boot_ctrl.sv
`timescale 1ns/1ps
// Module: core_boot_ctrl (top)
// Memory-mapped reset and boot controller for a four-core cluster.
// Decodes word-aligned accesses into a 16-word register file, flags bad
// addresses, and turns control-register writes into per-core strobes.
// Assumes one access per cycle and the bit layout in cbc_pkg.
module core_boot_ctrl
    import cbc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DW     = CBC_DW,
    parameter int NCORES = CBC_NCORES,
    parameter int NREGS  = CBC_NREGS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic                 bus_re,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_err,
    output logic [NCORES-1:0]    core_rst_pulse,
    output logic [NCORES-1:0]    core_on_pulse,
    output logic [NCORES-1:0]    core_off_pulse,
    output logic [NCORES*DW-1:0] core_entry_addr,
    output logic [NCORES*DW-1:0] core_entry_arg
);

    localparam int IW  = $clog2(NREGS);
    localparam int WIW = ADDR_W - 2;

    logic [WIW-1:0]          word_idx;
    logic [IW-1:0]           sel;
    logic                    in_range;
    logic                    wr_ok;
    logic                    ctrl_hit;
    logic [DW-1:0]           ctrl_store;
    logic [DW-1:0]           store_data;
    logic [NREGS*DW-1:0]     regs_flat;
    logic [NCORES-1:0]       rst_req;
    logic [NCORES-1:0]       on_req;
    logic [NCORES-1:0]       off_req;
    logic [NCORES*DW-1:0]    entry_taps;
    logic [NCORES*DW-1:0]    arg_taps;

    // Address decode: aligned word inside the register file.
    assign word_idx   = bus_addr[ADDR_W-1:2];
    assign sel        = word_idx[IW-1:0];
    assign in_range   = (bus_addr[1:0] == 2'b00) && (word_idx < WIW'(NREGS));
    assign wr_ok      = bus_we && in_range;
    assign ctrl_hit   = wr_ok && (sel == IW'(IDX_CTRL));
    assign store_data = ctrl_hit ? ctrl_store : bus_wdata;

    // Read path and error flag: out-of-range or unaligned reads return 0.
    assign bus_rdata = in_range ? regs_flat[sel*DW +: DW] : '0;
    assign bus_err   = (bus_we || bus_re) && !in_range;

    cbc_regfile #(
        .DW    (DW),
        .NREGS (NREGS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ok),
        .wr_idx    (sel),
        .wr_data   (store_data),
        .regs_flat (regs_flat)
    );

    cbc_ctrl_decode #(
        .DW     (DW),
        .NCORES (NCORES)
    ) u_decode (
        .apply      (ctrl_hit),
        .ctrl_q     (regs_flat[IDX_CTRL*DW +: DW]),
        .wdata      (bus_wdata),
        .ctrl_store (ctrl_store),
        .rst_req    (rst_req),
        .on_req     (on_req),
        .off_req    (off_req)
    );

    // Per-core taps of the general registers holding entry address/argument.
    for (genvar n = 0; n < NCORES; n++) begin : g_tap
        if (n == 0) begin : g_primary
            assign entry_taps[n*DW +: DW] = '0;
            assign arg_taps[n*DW +: DW]   = '0;
        end else begin : g_secondary
            assign entry_taps[n*DW +: DW] = regs_flat[entry_addr_idx(n)*DW +: DW];
            assign arg_taps[n*DW +: DW]   = regs_flat[entry_arg_idx(n)*DW +: DW];
        end
    end

    cbc_strobe_reg #(
        .DW     (DW),
        .NCORES (NCORES)
    ) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .on_req    (on_req),
        .off_req   (off_req),
        .entry_in  (entry_taps),
        .arg_in    (arg_taps),
        .rst_pulse (core_rst_pulse),
        .on_pulse  (core_on_pulse),
        .off_pulse (core_off_pulse),
        .entry_out (core_entry_addr),
        .arg_out   (core_entry_arg)
    );

endmodule

// File: rtl/cbc_checker.sv
`timescale 1ns/1ps
// Module: cbc_checker
// Protocol and state checks for core_boot_ctrl, attached with bind.
// Observes the ports plus the flat register state of the top.
module cbc_checker
    import cbc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DW     = 32,
    parameter int NCORES = 4,
    parameter int NREGS  = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_we,
    input logic                 bus_re,
    input logic [DW-1:0]        bus_rdata,
    input logic                 bus_err,
    input logic [NCORES-1:0]    core_rst_pulse,
    input logic [NCORES-1:0]    core_on_pulse,
    input logic [NCORES-1:0]    core_off_pulse,
    input logic [NCORES*DW-1:0] core_entry_addr,
    input logic [NREGS*DW-1:0]  regs_flat
);

    logic          was_in_rst = 1'b0;
    logic          bad_addr;
    logic [DW-1:0] ctrl_now;

    // Remembers that the previous edge was a reset edge.
    always @(posedge clk) was_in_rst <= !rst_n;

    assign bad_addr = (bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:2] >= (ADDR_W-2)'(NREGS));
    assign ctrl_now = regs_flat[IDX_CTRL*DW +: DW];

    // R1: reset values visible at the first edge after reset
    assert_reset_values_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_in_rst |-> (ctrl_now == DW'(CTRL_RESET_VAL)) &&
                       (regs_flat[IDX_RSTAT*DW +: DW] == DW'(RSTAT_RESET_VAL)) &&
                       (regs_flat[IDX_IMASK*DW +: DW] == DW'(IMASK_RESET_VAL)));

    // R3: bad read returns zero and flags
    assert_bad_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bad_addr) |-> (bus_rdata == '0) && bus_err);

    // R3: bad write leaves every register unchanged
    assert_bad_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bad_addr) |=> $stable(regs_flat));

    // R4: power-on carries the core's general-register pair
    for (genvar n = 1; n < NCORES; n++) begin : g_entry_chk
        assert_on_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
            core_on_pulse[n] |-> core_entry_addr[n*DW +: DW] ==
                                 $past(regs_flat[entry_addr_idx(n)*DW +: DW]));
    end

    // R5: a core never gets power-on and power-off together
    assert_on_off_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_on_pulse & core_off_pulse) == '0);

    // R6: a power strobe suppresses the same core's reset strobe
    assert_power_eats_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((core_on_pulse | core_off_pulse) & core_rst_pulse) == '0);

    // R7: stored core reset bits are always zero
    assert_rst_bits_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_now[BIT_RST_BASE +: NCORES] == '0);

    // R8: stored display-unit reset bits are always zero
    assert_disp_bits_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_now[BIT_DISP1] && !ctrl_now[BIT_DISP2]);

    // R10: any strobe follows a write to the control register
    assert_strobe_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|{core_rst_pulse, core_on_pulse, core_off_pulse}) |->
            $past(bus_we && (bus_addr == '0)));

    // R10: core 0 never gets a power strobe
    assert_core0_no_power_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !core_on_pulse[0] && !core_off_pulse[0]);

endmodule

bind core_boot_ctrl cbc_checker #(
    .ADDR_W (ADDR_W),
    .DW     (DW),
    .NCORES (NCORES),
    .NREGS  (NREGS)
) u_cbc_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_we          (bus_we),
    .bus_re          (bus_re),
    .bus_rdata       (bus_rdata),
    .bus_err         (bus_err),
    .core_rst_pulse  (core_rst_pulse),
    .core_on_pulse   (core_on_pulse),
    .core_off_pulse  (core_off_pulse),
    .core_entry_addr (core_entry_addr),
    .regs_flat       (regs_flat)
);

// File: tb/test_core_boot_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared against the ports every cycle.
module test_core_boot_ctrl;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [11:0]  bus_addr;
    logic         bus_we;
    logic         bus_re;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic         bus_err;
    logic [3:0]   core_rst_pulse;
    logic [3:0]   core_on_pulse;
    logic [3:0]   core_off_pulse;
    logic [127:0] core_entry_addr;
    logic [127:0] core_entry_arg;

    int vectors     = 0;
    int miscompares = 0;

    // reference model state
    logic [31:0] mreg [16];
    logic [3:0]  e_rst, e_on, e_off;
    logic [127:0] e_addr, e_arg;

    always #2.5 clk = ~clk;

    core_boot_ctrl i_core_boot_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .bus_we          (bus_we),
        .bus_re          (bus_re),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .bus_err         (bus_err),
        .core_rst_pulse  (core_rst_pulse),
        .core_on_pulse   (core_on_pulse),
        .core_off_pulse  (core_off_pulse),
        .core_entry_addr (core_entry_addr),
        .core_entry_arg  (core_entry_arg)
    );

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference behaviour of a control write, from the requirements.
    task automatic model_ctrl(input logic [31:0] d);
        logic [31:0] cur, chg;
        cur = d;
        chg = mreg[0] ^ d;
        for (int n = 1; n < 4; n++) begin
            if (chg[21+n]) begin
                if (d[21+n]) begin
                    e_on[n] = 1'b1;
                    e_addr[n*32 +: 32] = mreg[6+2*n];
                    e_arg[n*32 +: 32]  = mreg[7+2*n];
                end else begin
                    e_off[n] = 1'b1;
                end
                cur[13+n] = 1'b0;
                chg[13+n] = 1'b0;
            end
        end
        for (int n = 0; n < 4; n++) begin
            if (chg[13+n]) begin
                e_rst[n]  = 1'b1;
                cur[13+n] = 1'b0;
            end
        end
        if (chg[3])  cur[3]  = 1'b0;
        if (chg[12]) cur[12] = 1'b0;
        mreg[0] = cur;
    endtask

    // One bus cycle: drive, check combinational outputs, then strobes.
    task automatic step(input bit we, input bit re, input logic [11:0] a,
                        input logic [31:0] d, input string req);
        bit ok;
        int idx;
        @(negedge clk);
        bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
        #1;
        idx = int'(a >> 2);
        ok  = (a[1:0] == 2'b00) && (idx < 16);
        check(req, "rdata", {96'h0, bus_rdata}, ok ? {96'h0, mreg[idx]} : 128'h0);
        check(req, "err", {127'h0, bus_err}, {127'h0, (we || re) && !ok});
        e_rst = '0; e_on = '0; e_off = '0; e_addr = '0; e_arg = '0;
        if (we && ok) begin
            if (idx == 0) model_ctrl(d);
            else mreg[idx] = d;
        end
        @(posedge clk);
        #1;
        check(req, "rst_pulse", {124'h0, core_rst_pulse}, {124'h0, e_rst});
        check(req, "on_pulse",  {124'h0, core_on_pulse},  {124'h0, e_on});
        check(req, "off_pulse", {124'h0, core_off_pulse}, {124'h0, e_off});
        check(req, "entry_addr", core_entry_addr, e_addr);
        check(req, "entry_arg",  core_entry_arg,  e_arg);
    endtask

    task automatic rd(input int idx, input string req);
        step(1'b0, 1'b1, 12'(idx*4), 32'h0, req);
    endtask

    task automatic wr(input int idx, input logic [31:0] d, input string req);
        step(1'b1, 1'b0, 12'(idx*4), d, req);
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < 16; i++) rd(i, req);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #1000000;
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_we = 1'b0; bus_re = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        for (int i = 0; i < 16; i++) mreg[i] = 32'h0;
        mreg[0] = 32'h521; mreg[1] = 32'h1; mreg[2] = 32'h1F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_all("R1");

        // R3: bad reads past the end and unaligned
        rd(16, "R3");
        rd(1023, "R3");
        step(1'b0, 1'b1, 12'h002, 32'h0, "R3");

        // R2: plain registers store and read back
        for (int k = 1; k <= 10; k++) wr(5 + k, 32'hA000_0000 + 32'(k * 32'h111), "R2");
        wr(1, 32'h0000_0004, "R2");
        wr(2, 32'h0000_0003, "R2");
        wr(3, 32'hDEAD_BEEF, "R2");
        wr(4, 32'h1234_5678, "R2");
        wr(5, 32'h8765_4321, "R2");
        read_all("R2");

        // R3: bad writes change nothing
        wr(16, 32'hFFFF_FFFF, "R3");
        step(1'b1, 1'b0, 12'hFFC, 32'hFFFF_FFFF, "R3");
        step(1'b1, 1'b0, 12'h001, 32'hFFFF_FFFF, "R3");
        read_all("R3");

        // R4: core 1 on, entry from general registers 3 and 4
        wr(0, mreg[0] | (32'h1 << 22), "R4");
        rd(0, "R4");
        // R7: core 1 reset alone
        wr(0, mreg[0] | (32'h1 << 14), "R7");
        rd(0, "R7");
        // R6: core 2 enable plus its reset bit: power only
        wr(0, mreg[0] | (32'h1 << 23) | (32'h1 << 15), "R6");
        rd(0, "R6");
        // R7: cores 0 and 3 reset together
        wr(0, mreg[0] | (32'h1 << 13) | (32'h1 << 16), "R7");
        // R8: display-unit bits
        wr(0, mreg[0] | (32'h1 << 3) | (32'h1 << 12), "R8");
        rd(0, "R8");
        // R5: core 1 off while core 3 on
        wr(0, (mreg[0] & ~(32'h1 << 22)) | (32'h1 << 24), "R5");
        // R9: unchanged rewrite, then plain bits
        wr(0, mreg[0], "R9");
        wr(0, mreg[0] ^ 32'h0000_0401, "R9");
        rd(0, "R9");
        // R6: all enables off with all reset bits set
        wr(0, (mreg[0] & ~(32'h7 << 22)) | (32'hF << 13), "R6");
        rd(0, "R6");
        // R4: new entry pair for core 1, then on again
        wr(8, 32'h0BAD_F00D, "R4");
        wr(9, 32'h0000_CAFE, "R4");
        wr(0, mreg[0] | (32'h1 << 22) | (32'h1 << 24), "R4");
        // R10: back-to-back control writes, then idle cycles
        wr(0, mreg[0] | (32'h1 << 13), "R10");
        wr(0, mreg[0] | (32'h1 << 13), "R10");
        step(1'b0, 1'b0, 12'h0, 32'h0, "R10");
        step(1'b0, 1'b0, 12'h0, 32'h0, "R10");
        read_all("R10");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule